// File: doc/BRIEF.md
# Gated 13/16-bit Timer-Counter

This block is a two-byte up-counter that measures either elapsed time or external events. Its count source is a fixed divide-by-six of the block clock (timer use) or falling edges on an external count pin (event use). A run bit starts and stops counting. A gate bit can make counting also depend on an active-low external pin, which suits pulse-width measurement: the count advances only while that pin sits at its inactive (high) level.

Two counting layouts are supported. In the wide layout the low and high bytes form one 16-bit counter. In the narrow layout only the five lowest bits of the low byte count, as a modulo-32 prescaler, and every prescaler wrap advances the high byte, giving a 13-bit count. When the count passes from all ones to zero, the block raises a sticky overflow flag and a one-cycle interrupt request pulse. Software reads both bytes directly and loads either byte with a one-cycle write strobe. Software should stop the counter before it changes the layout.

Top module: `gtc_timer`

## Requirements
- R1: After reset, hi_q and lo_q are 0x00 and ovf_flag and irq_req are 0.
- R2: With gate_en = 0, run = 1 alone enables counting; with run = 0 and no write, hi_q and lo_q hold their values.
- R3: With gate_en = 1 and run = 1, counting advances only while ext_gate_n, after a two-flop synchronizer, reads 1; while it reads 0 the count holds.
- R4: With ext_src = 0 the count source is one tick per 6 enabled clock edges; the divider restarts from zero whenever counting is disabled, so the first increment lands on the 6th enabled edge.
- R5: With ext_src = 1, each falling edge of ext_cnt_pin gives exactly one increment, on the third clock edge after the pin falls (two synchronizer flops plus edge detection); rising edges give none.
- R6: With mode16 = 0, lo_q[4:0] counts modulo 32 and each wrap from 31 to 0 increments hi_q.
- R7: With mode16 = 0, counting never changes lo_q[7:5].
- R8: With mode16 = 1, lo_q increments on each tick and a carry from 0xFF into 0x00 increments hi_q.
- R9: An increment that takes the counter from all ones to zero (hi_q = 0xFF with lo_q = 0xFF in 16-bit use, or lo_q[4:0] = 31 in 13-bit use) sets ovf_flag and drives irq_req high for exactly that one cycle.
- R10: In 13-bit timer use, starting from a loaded count C = hi_q*32 + lo_q[4:0], ovf_flag rises on enabled clock edge number 6 × (8192 − C).
- R11: ovf_flag stays set until flag_clr is sampled high; an overflow on the same edge as flag_clr leaves the flag set.
- R12: A write strobe (wr_hi or wr_lo) on the same edge as a count tick wins: the written byte takes wr_data, and that tick is dropped entirely.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock, also the timer reference |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_hi | input | 1 | Load strobe for the high byte |
| wr_lo | input | 1 | Load strobe for the low byte |
| wr_data | input | 8 | Data for byte loads |
| mode16 | input | 1 | 1: full 16-bit cascade, 0: 13-bit with 5-bit prescaler |
| gate_en | input | 1 | 1: counting also requires ext_gate_n high |
| ext_src | input | 1 | 0: clock divided by 6, 1: falling edges of ext_cnt_pin |
| run | input | 1 | Run enable |
| ext_cnt_pin | input | 1 | Asynchronous external event input |
| ext_gate_n | input | 1 | Asynchronous active-low gating pin |
| flag_clr | input | 1 | Clears the overflow flag (interrupt acknowledge) |
| hi_q | output | 8 | High count byte |
| lo_q | output | 8 | Low count byte |
| ovf_flag | output | 1 | Sticky overflow flag |
| irq_req | output | 1 | One-cycle interrupt request pulse at overflow |

## Verification
The hardest conditions to reach are the collisions that must land on the exact edge of a count tick: a byte write that beats the increment, and a flag clear that meets an overflow. The stimulus gets there by relying on the divider restarting from zero when run rises, so after run is raised the bench counts five edges and drives the strobe across the sixth, which is known to carry the tick. The same restart property lets the bench measure the 13-bit overflow period as an exact edge count from run rising to the flag, for two loaded values, one of which crosses a prescaler wrap.

// File: rtl/gtc_pkg.sv
package gtc_pkg;

   typedef enum logic {
      CNT_NARROW = 1'b0,
      CNT_WIDE   = 1'b1
   } cnt_mode_e;

   typedef enum logic {
      SRC_DIV = 1'b0,
      SRC_PIN = 1'b1
   } cnt_src_e;

   function automatic logic falling(input logic prev_lvl, input logic cur_lvl);
      return prev_lvl & ~cur_lvl;
   endfunction

endpackage

// File: rtl/gtc_sync.sv
module gtc_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_LVL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[0] <= RST_LVL;
            else        chain[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[i] <= RST_LVL;
            else        chain[i] <= chain[i-1];
         end
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/gtc_tick_src.sv
module gtc_tick_src
   import gtc_pkg::*;
#(
   parameter int DIV_RATIO   = 6,
   parameter int SYNC_STAGES = 2
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     cnt_en,
   input  cnt_src_e src_sel,
   input  logic     pin_raw,
   output logic     tick
);
   localparam int DIV_W = (DIV_RATIO > 1) ? $clog2(DIV_RATIO) : 1;
   localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(DIV_RATIO - 1);

   logic [DIV_W-1:0] div_q;
   logic             div_wrap;
   logic             pin_s;
   logic             pin_prev;
   logic             pin_fall;

   // divider restarts whenever counting is disabled
   assign div_wrap = (div_q == DIV_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        div_q <= '0;
      else if (!cnt_en)  div_q <= '0;
      else if (div_wrap) div_q <= '0;
      else               div_q <= div_q + DIV_W'(1);
   end

   gtc_sync #(.STAGES(SYNC_STAGES), .RST_LVL(1'b1)) u_pin_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pin_raw),
      .q     (pin_s)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pin_prev <= 1'b1;
      else        pin_prev <= pin_s;
   end

   assign pin_fall = falling(pin_prev, pin_s);

   always_comb begin
      unique case (src_sel)
         SRC_PIN: tick = cnt_en & pin_fall;
         default: tick = cnt_en & div_wrap;
      endcase
   end
endmodule

// File: rtl/gtc_count_core.sv
module gtc_count_core
   import gtc_pkg::*;
#(
   parameter int BYTE_W = 8,
   parameter int PRE_W  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  cnt_mode_e         mode,
   input  logic              wr_hi,
   input  logic              wr_lo,
   input  logic [BYTE_W-1:0] wr_data,
   output logic [BYTE_W-1:0] hi_q,
   output logic [BYTE_W-1:0] lo_q,
   output logic              wrap_evt
);
   localparam int WIDE_W = 2 * BYTE_W;

   logic [BYTE_W-1:0] hi_r, lo_r;
   logic [BYTE_W-1:0] hi_w, lo_w, hi_n13, lo_n13;
   logic [BYTE_W-1:0] hi_nx, lo_nx;
   logic [PRE_W-1:0]  pre_nx;
   logic              pre_carry, wrap_w, wrap_13, wrap_nx, any_wr;

   // full cascade
   always_comb begin
      {wrap_w, hi_w, lo_w} = {1'b0, hi_r, lo_r} + (WIDE_W + 1)'(1);
   end

   // prescaler plus high byte
   always_comb begin
      {pre_carry, pre_nx} = {1'b0, lo_r[PRE_W-1:0]} + (PRE_W + 1)'(1);
      hi_n13  = hi_r + BYTE_W'(pre_carry);
      wrap_13 = pre_carry & (&hi_r);
   end

   if (PRE_W < BYTE_W) begin : g_keep_upper
      assign lo_n13 = {lo_r[BYTE_W-1:PRE_W], pre_nx};
   end else begin : g_full_pre
      assign lo_n13 = pre_nx;
   end

   always_comb begin
      unique case (mode)
         CNT_WIDE: begin
            hi_nx   = hi_w;
            lo_nx   = lo_w;
            wrap_nx = wrap_w;
         end
         default: begin
            hi_nx   = hi_n13;
            lo_nx   = lo_n13;
            wrap_nx = wrap_13;
         end
      endcase
   end

   assign any_wr = wr_hi | wr_lo;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_r <= '0;
         lo_r <= '0;
      end else if (any_wr) begin
         if (wr_hi) hi_r <= wr_data;
         if (wr_lo) lo_r <= wr_data;
      end else if (tick) begin
         hi_r <= hi_nx;
         lo_r <= lo_nx;
      end
   end

   assign wrap_evt = tick & ~any_wr & wrap_nx;
   assign hi_q     = hi_r;
   assign lo_q     = lo_r;
endmodule

// File: rtl/gtc_timer.sv
module gtc_timer
   import gtc_pkg::*;
#(
   parameter int BYTE_W      = 8,
   parameter int PRE_W       = 5,
   parameter int DIV_RATIO   = 6,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_hi,
   input  logic              wr_lo,
   input  logic [BYTE_W-1:0] wr_data,
   input  logic              mode16,
   input  logic              gate_en,
   input  logic              ext_src,
   input  logic              run,
   input  logic              ext_cnt_pin,
   input  logic              ext_gate_n,
   input  logic              flag_clr,
   output logic [BYTE_W-1:0] hi_q,
   output logic [BYTE_W-1:0] lo_q,
   output logic              ovf_flag,
   output logic              irq_req
);
   // elaboration-time parameter checks
   if (BYTE_W < 2) begin : g_bad_byte
      $error("gtc_timer: BYTE_W must be at least 2");
   end
   if (PRE_W < 1 || PRE_W > BYTE_W) begin : g_bad_pre
      $error("gtc_timer: PRE_W must lie in 1..BYTE_W");
   end
   if (DIV_RATIO < 2) begin : g_bad_div
      $error("gtc_timer: DIV_RATIO must be at least 2");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("gtc_timer: SYNC_STAGES must be at least 2");
   end

   logic gate_s;
   logic cnt_en;
   logic tick;
   logic wrap_evt;
   logic flag_r, irq_r;

   gtc_sync #(.STAGES(SYNC_STAGES), .RST_LVL(1'b1)) u_gate_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (ext_gate_n),
      .q     (gate_s)
   );

   assign cnt_en = run & (~gate_en | gate_s);

   gtc_tick_src #(.DIV_RATIO(DIV_RATIO), .SYNC_STAGES(SYNC_STAGES)) u_tick (
      .clk     (clk),
      .rst_n   (rst_n),
      .cnt_en  (cnt_en),
      .src_sel (cnt_src_e'(ext_src)),
      .pin_raw (ext_cnt_pin),
      .tick    (tick)
   );

   gtc_count_core #(.BYTE_W(BYTE_W), .PRE_W(PRE_W)) u_core (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .mode     (cnt_mode_e'(mode16)),
      .wr_hi    (wr_hi),
      .wr_lo    (wr_lo),
      .wr_data  (wr_data),
      .hi_q     (hi_q),
      .lo_q     (lo_q),
      .wrap_evt (wrap_evt)
   );

   // set wins over clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_r <= 1'b0;
         irq_r  <= 1'b0;
      end else begin
         irq_r <= wrap_evt;
         if (wrap_evt)      flag_r <= 1'b1;
         else if (flag_clr) flag_r <= 1'b0;
      end
   end

   assign ovf_flag = flag_r;
   assign irq_req  = irq_r;
endmodule

// File: rtl/gtc_timer_chk.sv
module gtc_timer_chk #(
   parameter int BYTE_W = 8,
   parameter int PRE_W  = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              run,
   input logic              wr_hi,
   input logic              wr_lo,
   input logic              mode16,
   input logic              flag_clr,
   input logic [BYTE_W-1:0] hi_q,
   input logic [BYTE_W-1:0] lo_q,
   input logic              ovf_flag,
   input logic              irq_req
);
   // R2: stopped and not written means no change
   a_r2_hold_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !wr_hi && !wr_lo) |=> ($stable(hi_q) && $stable(lo_q)));

   // R7: upper low-byte bits untouched by narrow counting
   if (PRE_W < BYTE_W) begin : g_upper
      a_r7_upper_bits_kept: assert property (@(posedge clk) disable iff (!rst_n)
         (!mode16 && !wr_lo) |=> (lo_q[BYTE_W-1:PRE_W] == $past(lo_q[BYTE_W-1:PRE_W])));
   end

   // R9: request only out of an all-ones high byte
   a_r9_irq_from_ones: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> ($past(hi_q) == {BYTE_W{1'b1}}));

   // R9: request lasts one cycle
   a_r9_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |=> !irq_req);

   // R9: request comes with the flag
   a_r9_irq_with_flag: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> ovf_flag);

   // R11: flag sticky without a clear
   a_r11_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_flag && !flag_clr) |=> ovf_flag);

   // R11: clear works unless a new overflow arrives
   a_r11_clear_or_set: assert property (@(posedge clk) disable iff (!rst_n)
      flag_clr |=> (!ovf_flag || irq_req));
endmodule

bind gtc_timer gtc_timer_chk #(.BYTE_W(BYTE_W), .PRE_W(PRE_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .run      (run),
   .wr_hi    (wr_hi),
   .wr_lo    (wr_lo),
   .mode16   (mode16),
   .flag_clr (flag_clr),
   .hi_q     (hi_q),
   .lo_q     (lo_q),
   .ovf_flag (ovf_flag),
   .irq_req  (irq_req)
);

// File: tb/tb_gtc_timer.sv
module tb_gtc_timer;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_hi = 1'b0, wr_lo = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic       mode16 = 1'b0, gate_en = 1'b0, ext_src = 1'b0, run = 1'b0;
   logic       ext_cnt_pin = 1'b1, ext_gate_n = 1'b1, flag_clr = 1'b0;
   logic [7:0] hi_q, lo_q;
   logic       ovf_flag, irq_req;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   gtc_timer dut (
      .clk(clk), .rst_n(rst_n), .wr_hi(wr_hi), .wr_lo(wr_lo), .wr_data(wr_data),
      .mode16(mode16), .gate_en(gate_en), .ext_src(ext_src), .run(run),
      .ext_cnt_pin(ext_cnt_pin), .ext_gate_n(ext_gate_n), .flag_clr(flag_clr),
      .hi_q(hi_q), .lo_q(lo_q), .ovf_flag(ovf_flag), .irq_req(irq_req)
   );

   typedef struct {
      string      tag;
      logic [7:0] hi;
      logic [7:0] lo;
      logic       flag;
   } exp_t;

   exp_t sbq[$];

   // monitor: pops expected items and compares them with the outputs
   always begin
      wait (sbq.size() > 0);
      begin
         exp_t e;
         e = sbq.pop_front();
         checks++;
         if (hi_q !== e.hi || lo_q !== e.lo || ovf_flag !== e.flag) begin
            errors++;
            $display("FAIL %s: actual hi=%h lo=%h flag=%b expected hi=%h lo=%h flag=%b",
                     e.tag, hi_q, lo_q, ovf_flag, e.hi, e.lo, e.flag);
         end
      end
   end

   // driver side: push one expected item, let the monitor consume it
   task automatic expect_state(input string tag, input logic [7:0] h,
                               input logic [7:0] l, input logic f);
      exp_t e;
      e.tag = tag; e.hi = h; e.lo = l; e.flag = f;
      sbq.push_back(e);
      wait (sbq.size() == 0);
   endtask

   task automatic check_val(input string tag, input int act, input int exp_v);
      checks++;
      if (act != exp_v) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp_v);
      end
   endtask

   // all tasks start and end at a falling clock edge
   task automatic load(input logic [7:0] h, input logic [7:0] l);
      wr_hi = 1'b1; wr_data = h;
      @(negedge clk);
      wr_hi = 1'b0; wr_lo = 1'b1; wr_data = l;
      @(negedge clk);
      wr_lo = 1'b0;
   endtask

   task automatic run_edges(input int n);
      run = 1'b1;
      repeat (n) @(posedge clk);
      @(negedge clk);
      run = 1'b0;
   endtask

   task automatic pin_pulse();
      ext_cnt_pin = 1'b0;
      repeat (4) @(negedge clk);
      ext_cnt_pin = 1'b1;
      repeat (4) @(negedge clk);
   endtask

   function automatic int period13(input logic [7:0] h, input logic [7:0] l);
      return 6 * (8192 - (int'(h) * 32 + int'(l[4:0])));
   endfunction

   task automatic measure13(input string tag, input logic [7:0] h, input logic [7:0] l);
      int n;
      load(h, l);
      n = 0;
      run = 1'b1;
      while (!ovf_flag && n < 2000) begin
         @(posedge clk);
         n++;
         @(negedge clk);
      end
      run = 1'b0;
      check_val(tag, n, period13(h, l));
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      expect_state("R1 reset", 8'h00, 8'h00, 1'b0);
      check_val("R1 irq after reset", int'(irq_req), 0);

      // R8, R2, R4: 16-bit, 12 edges of timer source = 2 ticks, carry into high byte
      mode16 = 1'b1;
      load(8'h12, 8'hFE);
      run_edges(12);
      expect_state("R8 cascade carry", 8'h13, 8'h00, 1'b0);

      // R2: stopped timer holds
      repeat (20) @(negedge clk);
      expect_state("R2 hold while stopped", 8'h13, 8'h00, 1'b0);

      // R3: gate closed blocks counting
      gate_en = 1'b1;
      ext_gate_n = 1'b0;
      repeat (3) @(negedge clk);
      run = 1'b1;
      repeat (30) @(negedge clk);
      expect_state("R3 gate closed holds", 8'h13, 8'h00, 1'b0);
      // R3/R4: gate opens, 2 sync edges then ticks on edges 8, 14, 20
      ext_gate_n = 1'b1;
      repeat (20) @(posedge clk);
      @(negedge clk);
      run = 1'b0;
      gate_en = 1'b0;
      expect_state("R3 gate open counts", 8'h13, 8'h03, 1'b0);

      // R5: counter source, three falling edges
      ext_src = 1'b1;
      run = 1'b1;
      pin_pulse();
      pin_pulse();
      pin_pulse();
      run = 1'b0;
      ext_src = 1'b0;
      expect_state("R5 pin edges counted", 8'h13, 8'h06, 1'b0);

      // R12: write lands on the tick edge (6th enabled edge)
      load(8'h00, 8'h00);
      run = 1'b1;
      repeat (5) @(posedge clk);
      @(negedge clk);
      wr_lo = 1'b1; wr_data = 8'h40;
      @(negedge clk);
      wr_lo = 1'b0;
      run = 1'b0;
      expect_state("R12 write beats tick", 8'h00, 8'h40, 1'b0);

      // R6, R7: 13-bit prescaler wrap, upper bits of low byte kept
      mode16 = 1'b0;
      load(8'h10, 8'hFF);
      run_edges(6);
      expect_state("R6 prescaler wrap", 8'h11, 8'hE0, 1'b0);
      run_edges(6);
      expect_state("R7 upper bits kept", 8'h11, 8'hE1, 1'b0);

      // R10, R9: 13-bit overflow period, upper bits 101 kept
      measure13("R10 period from 0xFF/0xBC", 8'hFF, 8'hBC);
      check_val("R9 irq pulse at overflow", int'(irq_req), 1);
      expect_state("R9 wrap to zero", 8'h00, 8'hA0, 1'b1);
      @(negedge clk);
      check_val("R9 irq lasts one cycle", int'(irq_req), 0);
      expect_state("R11 flag sticky", 8'h00, 8'hA0, 1'b1);

      // R11: explicit clear
      flag_clr = 1'b1;
      @(negedge clk);
      flag_clr = 1'b0;
      expect_state("R11 flag cleared", 8'h00, 8'hA0, 1'b0);

      // R10, R6: second period crossing a prescaler wrap
      measure13("R10 period from 0xFE/0x1E", 8'hFE, 8'h1E);
      expect_state("R10 end state", 8'h00, 8'h00, 1'b1);
      flag_clr = 1'b1;
      @(negedge clk);
      flag_clr = 1'b0;

      // R11, R9: clear on the same edge as a 16-bit overflow
      mode16 = 1'b1;
      load(8'hFF, 8'hFF);
      run = 1'b1;
      repeat (5) @(posedge clk);
      @(negedge clk);
      flag_clr = 1'b1;
      @(negedge clk);
      flag_clr = 1'b0;
      run = 1'b0;
      check_val("R9 irq at 16-bit overflow", int'(irq_req), 1);
      expect_state("R11 set wins over clear", 8'h00, 8'h00, 1'b1);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog (R1..all): actual=timeout expected=completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule